// File: doc/BRIEF.md
# Program Counter Branch Target Unit

This block holds the 16-bit program counter of a small microcontroller with a 64 KB program space and picks the counter's next value on each instruction step. Every cycle it forms the sequential address (current PC plus instruction length) and one candidate branch target. The target can be a full 16-bit address, an 11-bit address kept inside the current 2 KB page, a signed 8-bit displacement, or an indexed address (data pointer plus accumulator).

The paged and relative forms both take their reference from the address of the instruction that follows the branch, not from the branching instruction. A decoder outside the block supplies the instruction length, a branch kind, the two operand bytes and a taken flag. The decoder raises the taken flag for unconditional branches and for conditions that hold. On a step, the PC loads the target when the branch kind is valid and taken is high. Otherwise it loads the sequential address.

A separate combinational output gives the address for a code-table read: the accumulator added to either the data pointer or the sequential address. All address arithmetic wraps modulo 2^16.

Top module: `pc_branch_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc_q` is 0x0000 after that edge.
- R2: With `rst` low and `step` low, `pc_q` keeps its value across the edge.
- R3: `seq_addr` equals `pc_q + ins_len` modulo 2^16 at all times.
- R4: For `br_kind` = 1 (long), `target` = {`op_hi`, `op_lo`}.
- R5: For `br_kind` = 2 (paged), `target` = {`seq_addr[15:11]`, `op_hi[2:0]`, `op_lo`}. The 11-bit field never carries into bit 11, so the target stays in the 2 KB page of the following instruction.
- R6: For `br_kind` = 3 (relative), `target` = `seq_addr` + sign-extended `op_lo` modulo 2^16, giving a reach of -128 to +127.
- R7: For `br_kind` = 4 (indexed), `target` = `dptr` + zero-extended `acc` modulo 2^16.
- R8: For `br_kind` = 0 (sequential) and the reserved codes 5 to 7, `target` equals `seq_addr`, and a step loads `seq_addr` even when `taken` is high.
- R9: On a step with `br_kind` in 1..4 and `taken` high, `pc_q` takes the `target` value present before the edge.
- R10: On a step with `taken` low, `pc_q` takes `seq_addr`, whatever `br_kind` is.
- R11: `lookup_addr` = (`lookup_pc` ? `seq_addr` : `dptr`) + zero-extended `acc` modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the PC this cycle |
| ins_len | input | 2 | Length in bytes of the current instruction |
| br_kind | input | 3 | Branch kind: 0 seq, 1 long, 2 paged, 3 relative, 4 indexed |
| taken | input | 1 | Redirect request for this instruction |
| op_hi | input | 8 | First operand byte (high address / page bits) |
| op_lo | input | 8 | Second operand byte (low address / displacement) |
| dptr | input | 16 | Data pointer value |
| acc | input | 8 | Accumulator value |
| lookup_pc | input | 1 | Lookup base select: 1 sequential address, 0 data pointer |
| pc_q | output | 16 | Registered program counter |
| seq_addr | output | 16 | Address of the following instruction |
| target | output | 16 | Branch target for the current branch kind |
| lookup_addr | output | 16 | Code-table lookup address |

## Verification
The hardest cases to reach from the ports need the PC to sit at a chosen spot first. These include a paged branch whose following instruction starts in a new 2 KB page, and relative branches that wrap through 0x0000 in either direction. The stimulus table gets there by chaining steps. Long jumps place the PC just below 0x0800 and just below 0xFFFF, and the next row issues the paged or relative branch from there. A reference model in the bench tracks the expected PC across the whole chain.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;
    typedef enum logic [2:0] {
        BK_SEQ   = 3'd0,
        BK_LONG  = 3'd1,
        BK_PAGE  = 3'd2,
        BK_REL   = 3'd3,
        BK_INDEX = 3'd4
    } br_kind_e;
endpackage

// File: rtl/pcbu_seq.sv
module pcbu_seq #(
    parameter int PC_W  = 16,
    parameter int LEN_W = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [LEN_W-1:0] len,
    output logic [PC_W-1:0]  seq
);
    localparam int PAD_W = PC_W - LEN_W;

    always_comb begin
        seq = pc + {{PAD_W{1'b0}}, len};
    end
endmodule

// File: rtl/pcbu_target.sv
module pcbu_target
    import pcbu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 11
) (
    input  logic [2:0]          kind,
    input  logic [2*BYTE_W-1:0] seq,
    input  logic [BYTE_W-1:0]   op_hi,
    input  logic [BYTE_W-1:0]   op_lo,
    input  logic [2*BYTE_W-1:0] dptr,
    input  logic [BYTE_W-1:0]   acc,
    output logic [2*BYTE_W-1:0] tgt,
    output logic                redirect
);
    localparam int PC_W  = 2 * BYTE_W;
    localparam int EXT_W = PC_W - BYTE_W;
    localparam int HI_W  = PAGE_W - BYTE_W;

    logic [PC_W-1:0] long_t, page_t, rel_t, idx_t;

    always_comb begin
        long_t = {op_hi, op_lo};
        page_t = {seq[PC_W-1:PAGE_W], op_hi[HI_W-1:0], op_lo};
        rel_t  = seq + {{EXT_W{op_lo[BYTE_W-1]}}, op_lo};
        idx_t  = dptr + {{EXT_W{1'b0}}, acc};
    end

    always_comb begin
        redirect = 1'b1;
        unique case (kind)
            BK_LONG:  tgt = long_t;
            BK_PAGE:  tgt = page_t;
            BK_REL:   tgt = rel_t;
            BK_INDEX: tgt = idx_t;
            default: begin
                tgt      = seq;
                redirect = 1'b0;
            end
        endcase
    end

    // R5: a paged target never leaves the page of the following instruction
    always_comb begin
        if (kind == BK_PAGE) begin
            assert_page_kept_R5: assert (tgt[PC_W-1:PAGE_W] == seq[PC_W-1:PAGE_W]);
        end
    end
endmodule

// File: rtl/pcbu_lookup.sv
module pcbu_lookup #(
    parameter int PC_W  = 16,
    parameter int ACC_W = 8
) (
    input  logic [PC_W-1:0]  seq,
    input  logic [PC_W-1:0]  dptr,
    input  logic [ACC_W-1:0] acc,
    input  logic             use_pc,
    output logic [PC_W-1:0]  addr
);
    localparam int PAD_W = PC_W - ACC_W;

    logic [PC_W-1:0] base;

    always_comb begin
        base = use_pc ? seq : dptr;
        addr = base + {{PAD_W{1'b0}}, acc};
    end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
    parameter int BYTE_W = 8,
    parameter int PAGE_W = 11,
    parameter int LEN_W  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [LEN_W-1:0]    ins_len,
    input  logic [2:0]          br_kind,
    input  logic                taken,
    input  logic [BYTE_W-1:0]   op_hi,
    input  logic [BYTE_W-1:0]   op_lo,
    input  logic [2*BYTE_W-1:0] dptr,
    input  logic [BYTE_W-1:0]   acc,
    input  logic                lookup_pc,
    output logic [2*BYTE_W-1:0] pc_q,
    output logic [2*BYTE_W-1:0] seq_addr,
    output logic [2*BYTE_W-1:0] target,
    output logic [2*BYTE_W-1:0] lookup_addr
);
    localparam int PC_W = 2 * BYTE_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;
    logic      redirect;

    pcbu_seq #(.PC_W(PC_W), .LEN_W(LEN_W)) u_seq (
        .pc  (st_q.pc),
        .len (ins_len),
        .seq (seq_addr)
    );

    pcbu_target #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_tgt (
        .kind     (br_kind),
        .seq      (seq_addr),
        .op_hi    (op_hi),
        .op_lo    (op_lo),
        .dptr     (dptr),
        .acc      (acc),
        .tgt      (target),
        .redirect (redirect)
    );

    pcbu_lookup #(.PC_W(PC_W), .ACC_W(BYTE_W)) u_lkp (
        .seq    (seq_addr),
        .dptr   (dptr),
        .acc    (acc),
        .use_pc (lookup_pc),
        .addr   (lookup_addr)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.pc = (taken && redirect) ? target : seq_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_q = st_q.pc;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc_q));

    assert_taken_loads_R9: assert property (@(posedge clk) disable iff (rst)
        (step && taken && br_kind inside {3'd1, 3'd2, 3'd3, 3'd4})
        |=> (pc_q == $past(target)));

    assert_not_taken_seq_R10: assert property (@(posedge clk) disable iff (rst)
        (step && !taken) |=> (pc_q == $past(seq_addr)));

    assert_seq_kind_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !(br_kind inside {3'd1, 3'd2, 3'd3, 3'd4}))
        |=> (pc_q == $past(seq_addr)));
endmodule

// File: tb/pc_branch_unit_test.sv
module pc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst, step, taken, lookup_pc;
    logic [1:0]  ins_len;
    logic [2:0]  br_kind;
    logic [7:0]  op_hi, op_lo, acc;
    logic [15:0] dptr;
    logic [15:0] pc_q, seq_addr, target, lookup_addr;

    int total = 0;
    int bad   = 0;
    logic [15:0] model_pc;

    always #2 clk = ~clk;

    pc_branch_unit uut (
        .clk(clk), .rst(rst), .step(step), .ins_len(ins_len), .br_kind(br_kind),
        .taken(taken), .op_hi(op_hi), .op_lo(op_lo), .dptr(dptr), .acc(acc),
        .lookup_pc(lookup_pc), .pc_q(pc_q), .seq_addr(seq_addr), .target(target),
        .lookup_addr(lookup_addr)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  len;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic        tk;
        logic [15:0] dp;
        logic [7:0]  ac;
        logic        lpc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd1, 8'h00, 8'h00, 1'b0, 16'h1000, 8'h03, 1'b0},
        '{3'd0, 2'd3, 8'hAA, 8'h55, 1'b1, 16'h2000, 8'h10, 1'b1},
        '{3'd1, 2'd3, 8'h12, 8'h34, 1'b1, 16'h0000, 8'h00, 1'b0},
        '{3'd3, 2'd2, 8'h00, 8'h10, 1'b0, 16'h0100, 8'h01, 1'b1},
        '{3'd3, 2'd2, 8'h00, 8'hF0, 1'b1, 16'hFFFF, 8'h01, 1'b0},
        '{3'd1, 2'd3, 8'h07, 8'hFE, 1'b1, 16'h0000, 8'h00, 1'b0},
        '{3'd2, 2'd2, 8'h05, 8'h55, 1'b1, 16'h0000, 8'h00, 1'b1},
        '{3'd4, 2'd1, 8'h00, 8'h00, 1'b1, 16'hFFF0, 8'h20, 1'b0},
        '{3'd1, 2'd3, 8'hFF, 8'hFE, 1'b1, 16'h0000, 8'h00, 1'b0},
        '{3'd3, 2'd2, 8'h00, 8'h05, 1'b1, 16'h0000, 8'hFF, 1'b1},
        '{3'd3, 2'd2, 8'h00, 8'h80, 1'b1, 16'h0000, 8'h00, 1'b0},
        '{3'd2, 2'd3, 8'hFF, 8'hFF, 1'b0, 16'hFF80, 8'hFF, 1'b1},
        '{3'd7, 2'd2, 8'h12, 8'h34, 1'b1, 16'h0000, 8'h00, 1'b0},
        '{3'd2, 2'd2, 8'hFF, 8'h01, 1'b1, 16'h0000, 8'h00, 1'b0}
    };

    function automatic logic [15:0] ref_seq(logic [15:0] pc, logic [1:0] len);
        return pc + {14'd0, len};
    endfunction

    function automatic logic [15:0] ref_target(vec_t v, logic [15:0] s);
        case (v.kind)
            3'd1:    return {v.hi, v.lo};
            3'd2:    return {s[15:11], v.hi[2:0], v.lo};
            3'd3:    return s + {{8{v.lo[7]}}, v.lo};
            3'd4:    return v.dp + {8'd0, v.ac};
            default: return s;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        br_kind = v.kind; ins_len = v.len; op_hi = v.hi; op_lo = v.lo;
        taken = v.tk; dptr = v.dp; acc = v.ac; lookup_pc = v.lpc;
    endtask

    task automatic do_step();
        step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; step = 1'b0; taken = 1'b0; lookup_pc = 1'b0;
        ins_len = 2'd1; br_kind = 3'd0; op_hi = 8'h00; op_lo = 8'h00;
        dptr = 16'h0000; acc = 8'h00;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset pc", pc_q, 16'h0000);
        rst = 1'b0;
        model_pc = 16'h0000;

        for (int i = 0; i < NV; i++) begin
            logic [15:0] es, et, el;
            logic        redir;
            drive(VECS[i]);
            #1;
            es = ref_seq(model_pc, VECS[i].len);
            et = ref_target(VECS[i], es);
            el = (VECS[i].lpc ? es : VECS[i].dp) + {8'd0, VECS[i].ac};
            chk("R3 seq_addr", seq_addr, es);
            case (VECS[i].kind)
                3'd1: chk("R4 long target", target, et);
                3'd2: chk("R5 paged target", target, et);
                3'd3: chk("R6 relative target", target, et);
                3'd4: chk("R7 indexed target", target, et);
                default: chk("R8 seq kind target", target, et);
            endcase
            chk("R11 lookup_addr", lookup_addr, el);
            redir = VECS[i].tk && (VECS[i].kind inside {3'd1, 3'd2, 3'd3, 3'd4});
            do_step();
            model_pc = redir ? et : es;
            if (redir)
                chk("R9 taken step pc", pc_q, model_pc);
            else if (!VECS[i].tk)
                chk("R10 not-taken step pc", pc_q, model_pc);
            else
                chk("R8 reserved/seq kind pc", pc_q, model_pc);
        end

        // R2: step low holds the PC even with a taken long branch presented
        drive('{3'd1, 2'd3, 8'hBE, 8'hEF, 1'b1, 16'h0000, 8'h00, 1'b0});
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle hold", pc_q, model_pc);

        // R1: reset during a taken step wins
        rst = 1'b1;
        step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        rst = 1'b0;
        chk("R1 reset over step", pc_q, 16'h0000);
        model_pc = 16'h0000;

        // R6: relative -128 from 0x0002 wraps to 0xFF82
        drive('{3'd3, 2'd2, 8'h00, 8'h80, 1'b1, 16'h0000, 8'h00, 1'b0});
        #1;
        chk("R6 relative wrap low", target, 16'hFF82);
        do_step();
        chk("R9 relative wrap pc", pc_q, 16'hFF82);

        // R5: paged target at 0x07FE len 2 lands in page 0x0800
        drive('{3'd1, 2'd3, 8'h07, 8'hFE, 1'b1, 16'h0000, 8'h00, 1'b0});
        do_step();
        drive('{3'd2, 2'd2, 8'h07, 8'hFF, 1'b1, 16'h0000, 8'h00, 1'b0});
        #1;
        chk("R5 page boundary target", target, 16'h0FFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule